// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address-latch strobe that tells an external latch when to capture the low address byte, and an active-low program-read strobe that enables external code memory onto the bus. Both are derived from the oscillator clock. A machine cycle spans a fixed number of oscillator clocks and is split into two halves, and each half carries one address-latch slot and one program-read slot.

The core supplies per-cycle context: whether code runs from external memory, whether the current machine cycle is an external data-memory transfer, whether a table-read or external-data-move instruction is executing, and a software bit that silences the address-latch strobe. All context inputs are sampled once, on the clock edge that opens a machine cycle, and govern the whole cycle. In a data-transfer cycle the first-half latch pulse and both program-read pulses are withheld, so the bus is free for the data transfer. When silenced, the latch output is parked high with only a weak hold (flagged on a separate output). The silence bit is overridden by external execution and by either data-move instruction.

Top module: `ext_bus_strobe`

## Requirements
- R1: While reset is asserted, and for two clocks after its release, `ale`=0, `ale_weak`=0 and `psen_n`=1. The third clock edge after release opens phase 0 of the first machine cycle.
- R2: A machine cycle lasts 12 clocks, numbered as phases 0 to 11. With the strobe enabled and no data transfer, `ale` is 1 in phases 0, 1, 6 and 7 and 0 elsewhere. This is one pulse per 6 clocks.
- R3: In a cycle sampled with `xdata_cyc`=1, `ale` stays 0 in phases 0 and 1, while the phase 6–7 pulse still occurs.
- R4: In a cycle sampled with `ale_off`=1, `ext_exec`=0, `movx_op`=0 and `movc_op`=0, `ale`=1 and `ale_weak`=1 in every phase.
- R5: With `ale_off`=1 and either `movx_op` or `movc_op` set, `ale` follows the pattern of R2/R3 and `ale_weak`=0.
- R6: With `ext_exec`=1, `ale_off` has no effect: `ale` follows R2/R3 and `ale_weak`=0.
- R7: In a cycle with `ext_exec`=1 and `xdata_cyc`=0, `psen_n` is 0 in phases 2–4 and 8–10 and 1 elsewhere. These windows never overlap an `ale` pulse.
- R8: In a cycle sampled with `xdata_cyc`=1, `psen_n` stays 1 for all 12 phases.
- R9: In a cycle sampled with `ext_exec`=0, `psen_n` stays 1 for all 12 phases.
- R10: Context inputs are sampled only on the edge that enters phase 0. Changes made after that edge have no effect on the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_exec | input | 1 | Code is fetched from external memory |
| xdata_cyc | input | 1 | Coming machine cycle is an external data-memory transfer |
| movx_op | input | 1 | External data-move instruction in progress |
| movc_op | input | 1 | Table-read instruction in progress |
| ale_off | input | 1 | Software bit silencing the address-latch strobe |
| ale | output | 1 | Address-latch strobe, active high |
| ale_weak | output | 1 | 1 when `ale` is only weakly held high (strobe silenced) |
| psen_n | output | 1 | Program-read strobe, active low |

## Verification
The bench uses the default parameters: 12 clocks per cycle, 2-clock latch pulses, and 3-clock read pulses starting at phase offset 2. With these values every phase slot can be observed individually, including the gaps between the latch and read windows. It walks through internal and external execution with and without data transfers, and through the silenced strobe alone, with each data-move instruction, and under external execution. It also changes every context input in mid-cycle and applies a reset in mid-run. For each clock the expected levels are taken from fixed phase numbers, not from the design's parameters.

// File: rtl/esg_pkg.sv
package esg_pkg;

  // Context that governs one whole machine cycle.
  typedef struct packed {
    logic ext;     // fetching from external code memory
    logic xdat;    // this cycle is an external data transfer
    logic ale_en;  // latch strobe actively driven this cycle
  } cyc_ctx_t;

  localparam cyc_ctx_t CTX_RESET = '{ext: 1'b0, xdat: 1'b0, ale_en: 1'b0};

endpackage

// File: rtl/esg_reset_sync.sv
module esg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/esg_phase_ctr.sv
module esg_phase_ctr #(
  parameter int CLK_PER_MC = 12,
  localparam int PH_W = $clog2(CLK_PER_MC),
  localparam int LAST = CLK_PER_MC - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_o,
  output logic [PH_W-1:0] ph_nxt_o,
  output logic            wrap_o
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            at_last;

  assign at_last = (ph_q == PH_W'(LAST));

  always_comb begin
    if (at_last) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  // Reset parks at the last phase so the first live edge opens phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_W'(LAST);
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph_o     = ph_q;
  assign ph_nxt_o = ph_d;
  assign wrap_o   = at_last;

  AST_PH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_W'(LAST)) |=> (ph_q == '0)); // R2

  AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_W'(LAST)) |=> (ph_q == $past(ph_q) + PH_W'(1))); // R2

endmodule

// File: rtl/esg_cycle_ctx.sv
module esg_cycle_ctx
  import esg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic     ext_exec_i,
  input  logic     xdata_i,
  input  logic     movx_i,
  input  logic     movc_i,
  input  logic     ale_off_i,
  output cyc_ctx_t ctx_o,
  output cyc_ctx_t ctx_nxt_o
);

  cyc_ctx_t ctx_q;
  cyc_ctx_t ctx_d;
  cyc_ctx_t sampled;

  always_comb begin
    sampled.ext    = ext_exec_i;
    sampled.xdat   = xdata_i;
    // Silence bit only counts for internal execution with no data move.
    sampled.ale_en = ext_exec_i | ~ale_off_i | movx_i | movc_i;
  end

  always_comb begin
    if (load_i) begin
      ctx_d = sampled;
    end else begin
      ctx_d = ctx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= CTX_RESET;
    end else begin
      ctx_q <= ctx_d;
    end
  end

  assign ctx_o     = ctx_q;
  assign ctx_nxt_o = ctx_d;

endmodule

// File: rtl/esg_strobe_dec.sv
module esg_strobe_dec
  import esg_pkg::*;
#(
  parameter int CLK_PER_MC = 12,
  parameter int ALE_W      = 2,
  parameter int PSEN_OFS   = 2,
  parameter int PSEN_W     = 3,
  localparam int PH_W      = $clog2(CLK_PER_MC),
  localparam int HALF      = CLK_PER_MC / 2,
  localparam int PSEN_END  = PSEN_OFS + PSEN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_nxt_i,
  input  cyc_ctx_t        ctx_nxt_i,
  output logic            ale_o,
  output logic            ale_weak_o,
  output logic            psen_n_o
);

  logic            second_half;
  logic [PH_W-1:0] half_ph;
  logic            ale_slot;
  logic            ale_drop;
  logic            psen_slot;
  logic            ale_d;
  logic            weak_d;
  logic            psen_n_d;

  always_comb begin
    second_half = (ph_nxt_i >= PH_W'(HALF));
    half_ph     = second_half ? (ph_nxt_i - PH_W'(HALF)) : ph_nxt_i;
    ale_slot    = (half_ph < PH_W'(ALE_W));
    psen_slot   = (half_ph >= PH_W'(PSEN_OFS)) && (half_ph < PH_W'(PSEN_END));
    // Data transfer gives up the first-half address pulse.
    ale_drop    = ctx_nxt_i.xdat && !second_half;

    if (ctx_nxt_i.ale_en) begin
      ale_d  = ale_slot && !ale_drop;
      weak_d = 1'b0;
    end else begin
      ale_d  = 1'b1;
      weak_d = 1'b1;
    end

    psen_n_d = !(ctx_nxt_i.ext && !ctx_nxt_i.xdat && psen_slot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_o      <= 1'b0;
      ale_weak_o <= 1'b0;
      psen_n_o   <= 1'b1;
    end else begin
      ale_o      <= ale_d;
      ale_weak_o <= weak_d;
      psen_n_o   <= psen_n_d;
    end
  end

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import esg_pkg::*;
#(
  parameter int CLK_PER_MC = 12,
  parameter int ALE_W      = 2,
  parameter int PSEN_OFS   = 2,
  parameter int PSEN_W     = 3,
  parameter int RST_STAGES = 2,
  localparam int PH_W      = $clog2(CLK_PER_MC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_exec,
  input  logic xdata_cyc,
  input  logic movx_op,
  input  logic movc_op,
  input  logic ale_off,
  output logic ale,
  output logic ale_weak,
  output logic psen_n
);

  logic            rst_int_n;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nxt;
  logic            wrap;
  cyc_ctx_t        ctx;
  cyc_ctx_t        ctx_nxt;

  esg_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  esg_phase_ctr #(.CLK_PER_MC(CLK_PER_MC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ph_o     (ph),
    .ph_nxt_o (ph_nxt),
    .wrap_o   (wrap)
  );

  esg_cycle_ctx u_ctx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (wrap),
    .ext_exec_i (ext_exec),
    .xdata_i    (xdata_cyc),
    .movx_i     (movx_op),
    .movc_i     (movc_op),
    .ale_off_i  (ale_off),
    .ctx_o      (ctx),
    .ctx_nxt_o  (ctx_nxt)
  );

  esg_strobe_dec #(
    .CLK_PER_MC (CLK_PER_MC),
    .ALE_W      (ALE_W),
    .PSEN_OFS   (PSEN_OFS),
    .PSEN_W     (PSEN_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ph_nxt_i   (ph_nxt),
    .ctx_nxt_i  (ctx_nxt),
    .ale_o      (ale),
    .ale_weak_o (ale_weak),
    .psen_n_o   (psen_n)
  );

  AST_PSEN_INT: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctx.ext |-> psen_n); // R9

  AST_XDAT_PSEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctx.xdat |-> psen_n); // R8

  AST_XDAT_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctx.xdat && ctx.ale_en && (ph < PH_W'(ALE_W))) |-> !ale); // R3

  AST_EXT_STRONG: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctx.ext |-> !ale_weak); // R6

  AST_WEAK_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    ale_weak |-> ale); // R4

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !psen_n |-> !ale); // R7

endmodule

// File: tb/tb_ext_bus_strobe.sv
module tb_ext_bus_strobe;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  a;
    logic  w;
    logic  p;
    string tag;
  } exp_t;

  logic clk;
  logic rst_n;
  logic ext_exec, xdata_cyc, movx_op, movc_op, ale_off;
  logic ale, ale_weak, psen_n;

  int checks;
  int fails;
  bit done;
  exp_t sb[$];

  ext_bus_strobe dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_exec  (ext_exec),
    .xdata_cyc (xdata_cyc),
    .movx_op   (movx_op),
    .movc_op   (movc_op),
    .ale_off   (ale_off),
    .ale       (ale),
    .ale_weak  (ale_weak),
    .psen_n    (psen_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected levels from the requirements' fixed phase numbers.
  function automatic exp_t expect_at(int p, bit ext, bit xd, bit en, string tag);
    exp_t e;
    int hp;
    hp = p % 6;
    if (!en) begin
      e.a = 1'b1;
      e.w = 1'b1;
    end else begin
      e.a = (hp < 2) && !(xd && p < 6);
      e.w = 1'b0;
    end
    e.p = !(ext && !xd && hp >= 2 && hp <= 4);
    e.tag = $sformatf("%s ph%0d", tag, p);
    return e;
  endfunction

  task automatic check3(string tag, logic a, logic w, logic p,
                        logic ea, logic ew, logic ep);
    checks++;
    if (a !== ea || w !== ew || p !== ep) begin
      fails++;
      $display("FAIL %s: ale/weak/psen_n actual %b%b%b expected %b%b%b",
               tag, a, w, p, ea, ew, ep);
    end
  endtask

  // Driver: called at a negedge just before the edge that opens phase 0.
  task automatic run_cycle(bit ext, bit xd, bit mx, bit mc, bit off,
                           bit scramble, string tag);
    bit en;
    en = ext | !off | mx | mc;
    for (int p = 0; p < 12; p++) sb.push_back(expect_at(p, ext, xd, en, tag));
    ext_exec = ext; xdata_cyc = xd; movx_op = mx; movc_op = mc; ale_off = off;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      if (scramble && k == 4) begin
        @(negedge clk);
        ext_exec = !ext; xdata_cyc = !xd; movx_op = !mx; movc_op = !mc; ale_off = !off;
      end
    end
    @(negedge clk);
  endtask

  // Monitor: compares one expected item per clock, shortly after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check3(e.tag, ale, ale_weak, psen_n, e.a, e.w, e.p);
      end
    end
  end

  task automatic reset_seq(string tag);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check3({tag, " in reset"}, ale, ale_weak, psen_n, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check3({tag, " sync1"}, ale, ale_weak, psen_n, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check3({tag, " sync2"}, ale, ale_weak, psen_n, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    ext_exec = 1'b0; xdata_cyc = 1'b0; movx_op = 1'b0; movc_op = 1'b0; ale_off = 1'b0;
    reset_seq("R1");
    run_cycle(0, 0, 0, 0, 0, 0, "R2 R9 internal");
    run_cycle(1, 0, 0, 0, 0, 0, "R2 R7 external");
    run_cycle(1, 1, 1, 0, 0, 0, "R3 R8 ext xdata");
    run_cycle(0, 1, 1, 0, 0, 0, "R3 R9 int xdata");
    run_cycle(0, 0, 0, 0, 1, 0, "R4 silenced");
    run_cycle(0, 0, 0, 0, 1, 0, "R4 silenced again");
    run_cycle(0, 0, 1, 0, 1, 0, "R5 off+movx");
    run_cycle(0, 1, 1, 0, 1, 0, "R5 off+movx xdata");
    run_cycle(0, 0, 0, 1, 1, 0, "R5 off+movc");
    run_cycle(1, 0, 0, 0, 1, 0, "R6 R7 off+ext");
    run_cycle(1, 1, 1, 0, 1, 0, "R6 R8 off+ext xdata");
    run_cycle(1, 0, 0, 0, 0, 1, "R10 ext scrambled");
    run_cycle(0, 0, 0, 0, 1, 1, "R10 silenced scrambled");
    run_cycle(0, 1, 1, 0, 0, 1, "R10 xdata scrambled");
    run_cycle(1, 0, 0, 0, 0, 0, "R7 external again");
    reset_seq("R1 midrun");
    run_cycle(1, 0, 0, 0, 1, 0, "R1 R6 after reset");
    @(posedge clk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule